// File: doc/BRIEF.md
# Fixed-Point Accumulate and Multiply Core

This block is the arithmetic heart of a 16-bit fixed-point signal processor. It holds a 32-bit accumulator behind a 32-bit add/subtract unit. A 16-bit operand from the data port is sign-extended. An input scaler then shifts it left by a count of 0 to 15 before the operand is loaded into the accumulator, added to it or subtracted from it.

A separate multiply path keeps one factor in a 16-bit temporary register. The other factor is taken from either the data port or the program port. The signed 32-bit product lands in a product register. A product scaler set by a 2-bit mode register passes the product through unchanged, shifts it left by 1 or by 4, or shifts it right arithmetically by 6 on its way into the accumulator. A store operation registers the accumulator's low half onto the result output.

A 4-bit opcode drives the block, one operation per clock. Every register changes on the rising edge and clears on synchronous reset. Instruction decode and memory addressing sit outside the block.

Top module: `dsp_mac_core`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, temporary register, product register, product-shift mode and `data_o` all become zero.
- R2: Opcode 1 (load) sets the accumulator to sign-extended `data_i` shifted left by `shift_i` (0 to 15). Bits shifted past bit 31 are lost.
- R3: Opcode 2 (add) adds the same shifted operand to the accumulator, modulo 2^32.
- R4: Opcode 3 (subtract) subtracts the same shifted operand from the accumulator, modulo 2^32.
- R5: Opcode 4 (load-temporary) copies `data_i` into the temporary register and leaves the accumulator unchanged.
- R6: Opcode 5 (multiply) writes the signed 32-bit product of the temporary register and the selected factor into the product register. The factor is `data_i` when `src_sel_i` is 0 and `prog_i` when it is 1. The accumulator is left unchanged.
- R7: Opcode 6 (set product mode) loads `data_i[1:0]` into the product-shift mode register.
- R8: Opcode 7 (accumulate product) adds the scaled product register to the accumulator, modulo 2^32. The mode sets the scaling: 0 passes the product unchanged, 1 shifts it left by 1, 2 shifts it left by 4, and 3 shifts it right arithmetically by 6.
- R9: Opcode 8 (store) places the accumulator's low 16 bits on `data_o` after the edge. `data_o` holds its value under every other opcode.
- R10: Opcode 0 and opcodes 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| shift_i | input | 4 | Left shift count for the data operand |
| data_i | input | 16 | Data operand |
| prog_i | input | 16 | Alternate multiplier factor |
| src_sel_i | input | 1 | Multiplier factor select (0 data, 1 program) |
| data_o | output | 16 | Stored low half of the accumulator |
| acc_o | output | 32 | Accumulator contents |

## Verification
The bench builds the core with its defaults: a 16-bit data width, a 32-bit accumulator and a 4-bit shift count. With these defaults every shift from 0 to 15 can be applied. A shift of 15 on 8000h pushes sign bits into the top of the accumulator. The extreme signed product 8000h × 8000h = 40000000h, scaled left by 1, reaches the accumulator's sign bit, so wrap-around and every product mode can be checked exactly. Random opcode streams, including the unused codes, are checked against a bench model after every operation.

// File: rtl/dsp_core_pkg.sv
package dsp_core_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_LDT   = 4'd4,
        OP_MPY   = 4'd5,
        OP_SPM   = 4'd6,
        OP_APAC  = 4'd7,
        OP_STORE = 4'd8
    } op_e;

    localparam int PMODE_W = 2;

endpackage

// File: rtl/dsp_in_shift.sv
module dsp_in_shift #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32,
    parameter int SH_W   = 4
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   sh,
    output logic [ACC_W-1:0]  dout
);
    localparam int EXT_W = ACC_W - DATA_W;

    logic [ACC_W-1:0] ext;

    assign ext  = {{EXT_W{din[DATA_W-1]}}, din};
    assign dout = ext << sh;
endmodule

// File: rtl/dsp_prod_shift.sv
module dsp_prod_shift #(
    parameter int ACC_W = 32,
    parameter int LSH_A = 1,
    parameter int LSH_B = 4,
    parameter int RSH   = 6
) (
    input  logic [ACC_W-1:0] prod,
    input  logic [1:0]       mode,
    output logic [ACC_W-1:0] scaled
);
    always_comb begin
        case (mode)
            2'd0:    scaled = prod;
            2'd1:    scaled = prod << LSH_A;
            2'd2:    scaled = prod << LSH_B;
            default: scaled = ACC_W'($signed(prod) >>> RSH);
        endcase
    end
endmodule

// File: rtl/dsp_calu.sv
module dsp_calu #(
    parameter int ACC_W = 32
) (
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    input  logic             sub,
    output logic [ACC_W-1:0] y
);
    assign y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/dsp_mac_core.sv
module dsp_mac_core
    import dsp_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [SH_W-1:0]   shift_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] prog_i,
    input  logic              src_sel_i,
    output logic [DATA_W-1:0] data_o,
    output logic [2*DATA_W-1:0] acc_o
);
    localparam int ACC_W = 2 * DATA_W;

    typedef struct packed {
        logic [ACC_W-1:0]   acc;
        logic [DATA_W-1:0]  treg;
        logic [ACC_W-1:0]   preg;
        logic [PMODE_W-1:0] pmode;
        logic [DATA_W-1:0]  dout;
    } state_t;

    state_t s_d, s_q;
    op_e    op;

    logic [ACC_W-1:0]  ish;
    logic [ACC_W-1:0]  psh;
    logic [ACC_W-1:0]  calu_b;
    logic [ACC_W-1:0]  calu_y;
    logic [DATA_W-1:0] mul_src;
    logic [ACC_W-1:0]  prod;

    assign op = op_e'(op_i);

    dsp_in_shift #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SH_W(SH_W)) u_in_shift (
        .din  (data_i),
        .sh   (shift_i),
        .dout (ish)
    );

    dsp_prod_shift #(.ACC_W(ACC_W)) u_prod_shift (
        .prod   (s_q.preg),
        .mode   (s_q.pmode),
        .scaled (psh)
    );

    assign calu_b = (op == OP_APAC) ? psh : ish;

    dsp_calu #(.ACC_W(ACC_W)) u_calu (
        .a   (s_q.acc),
        .b   (calu_b),
        .sub (op == OP_SUB),
        .y   (calu_y)
    );

    assign mul_src = src_sel_i ? prog_i : data_i;
    assign prod    = $signed({{DATA_W{s_q.treg[DATA_W-1]}}, s_q.treg})
                   * $signed({{DATA_W{mul_src[DATA_W-1]}}, mul_src});

    always_comb begin
        s_d = s_q;
        case (op)
            OP_LOAD:  s_d.acc   = ish;
            OP_ADD,
            OP_SUB,
            OP_APAC:  s_d.acc   = calu_y;
            OP_LDT:   s_d.treg  = data_i;
            OP_MPY:   s_d.preg  = prod;
            OP_SPM:   s_d.pmode = data_i[PMODE_W-1:0];
            OP_STORE: s_d.dout  = s_q.acc[DATA_W-1:0];
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign data_o = s_q.dout;
    assign acc_o  = s_q.acc;

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> s_q.acc == $past(ish))
        else $error("load did not take the scaled operand");

    p_ldt_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
        op == OP_LDT |=> $stable(s_q.acc) && $stable(s_q.preg))
        else $error("load-temporary disturbed accumulator or product");

    p_mpy_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
        op == OP_MPY |=> $stable(s_q.acc) && $stable(s_q.treg))
        else $error("multiply disturbed accumulator or temporary");

    p_store_low_r9: assert property (@(posedge clk) disable iff (rst)
        op == OP_STORE |=> data_o == $past(s_q.acc[DATA_W-1:0]))
        else $error("store did not capture the accumulator low half");

    p_store_hold_r9: assert property (@(posedge clk) disable iff (rst)
        op != OP_STORE |=> $stable(data_o))
        else $error("result output moved without a store");

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOP || op_i > 4'd8) |=> $stable(s_q.acc) && $stable(s_q.treg)
                                         && $stable(s_q.preg) && $stable(s_q.pmode))
        else $error("idle opcode changed state");
endmodule

// File: tb/tb_dsp_mac_core.sv
module tb_dsp_mac_core;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic [3:0]  shift_i;
    logic [15:0] data_i;
    logic [15:0] prog_i;
    logic        src_sel_i;
    logic [15:0] data_o;
    logic [31:0] acc_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_acc, m_preg;
    logic [15:0] m_treg, m_dout;
    logic [1:0]  m_pm;

    always #4 clk = ~clk;

    dsp_mac_core dut (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .shift_i   (shift_i),
        .data_i    (data_i),
        .prog_i    (prog_i),
        .src_sel_i (src_sel_i),
        .data_o    (data_o),
        .acc_o     (acc_o)
    );

    function automatic logic [31:0] scale_in(input logic [15:0] d, input logic [3:0] sh);
        logic signed [31:0] v;
        v = 32'(signed'(d));
        return 32'(v) << sh;
    endfunction

    function automatic logic [31:0] scale_prod(input logic [31:0] p, input logic [1:0] m);
        logic signed [31:0] s;
        s = signed'(p);
        case (m)
            2'd0: return p;
            2'd1: return p * 32'd2;
            2'd2: return p * 32'd16;
            default: return 32'(s / 64 - ((s < 0 && (s % 64) != 0) ? 1 : 0));
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] op, input logic [3:0] sh,
                         input logic [15:0] d, input logic [15:0] p, input logic sel);
        logic signed [31:0] a, b;
        case (op)
            4'd1: m_acc = scale_in(d, sh);
            4'd2: m_acc = m_acc + scale_in(d, sh);
            4'd3: m_acc = m_acc - scale_in(d, sh);
            4'd4: m_treg = d;
            4'd5: begin
                a = 32'(signed'(m_treg));
                b = 32'(signed'(sel ? p : d));
                m_preg = 32'(a * b);
            end
            4'd6: m_pm = d[1:0];
            4'd7: m_acc = m_acc + scale_prod(m_preg, m_pm);
            4'd8: m_dout = m_acc[15:0];
            default: ;
        endcase
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic do_op(input logic [3:0] op, input logic [3:0] sh,
                         input logic [15:0] d, input logic [15:0] p, input logic sel);
        op_i = op; shift_i = sh; data_i = d; prog_i = p; src_sel_i = sel;
        model(op, sh, d, p, sel);
        @(negedge clk);
        op_i = 4'd0;
        check32(req_of(op), acc_o, m_acc);
        check32((op == 4'd8) ? "R9" : req_of(op), {16'd0, data_o}, {16'd0, m_dout});
    endtask

    task automatic do_reset();
        rst = 1'b1; op_i = 4'd0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_acc = '0; m_preg = '0; m_treg = '0; m_dout = '0; m_pm = '0;
        check32("R1", acc_o, 32'd0);
        check32("R1", {16'd0, data_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'h5eed_c0de);
        rst = 1'b1; op_i = 4'd0; shift_i = '0; data_i = '0; prog_i = '0; src_sel_i = 1'b0;
        @(negedge clk);
        do_reset();

        // R3 / R9: 1111h + 2222h stored gives 3333h
        do_op(4'd1, 4'd0, 16'h1111, 16'h0, 1'b0);
        do_op(4'd2, 4'd0, 16'h2222, 16'h0, 1'b0);
        do_op(4'd8, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R9", {16'd0, data_o}, 32'h0000_3333);
        // R4: 3333h - 1111h gives 2222h
        do_op(4'd1, 4'd0, 16'h3333, 16'h0, 1'b0);
        do_op(4'd3, 4'd0, 16'h1111, 16'h0, 1'b0);
        do_op(4'd8, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R4", {16'd0, data_o}, 32'h0000_2222);
        // R3: shifted add by 2
        do_op(4'd2, 4'd2, 16'h1234, 16'h0, 1'b0);
        check32("R3", acc_o, 32'h0000_2222 + 32'h0000_48D0);
        // R2: shift 15 of the most negative operand
        do_op(4'd1, 4'd15, 16'h8000, 16'h0, 1'b0);
        check32("R2", acc_o, 32'hC000_0000);
        // R5 / R6 / R7 / R8: extreme product in every mode
        do_op(4'd4, 4'd0, 16'h8000, 16'h0, 1'b0);
        do_op(4'd5, 4'd0, 16'h8000, 16'h0, 1'b0);
        do_op(4'd1, 4'd0, 16'h0000, 16'h0, 1'b0);
        do_op(4'd6, 4'd0, 16'h0001, 16'h0, 1'b0);
        do_op(4'd7, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R8", acc_o, 32'h8000_0000);
        do_op(4'd5, 4'd0, 16'h0, 16'hFFFF, 1'b1);   // -32768 * -1 from program port
        do_op(4'd6, 4'd0, 16'h0003, 16'h0, 1'b0);
        do_op(4'd1, 4'd0, 16'h0000, 16'h0, 1'b0);
        do_op(4'd7, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R6", acc_o, 32'h0000_0200);
        do_op(4'd4, 4'd0, 16'hFFFD, 16'h0, 1'b0);   // -3 * 5 = -15
        do_op(4'd5, 4'd0, 16'h0005, 16'h0, 1'b0);
        do_op(4'd1, 4'd0, 16'h0000, 16'h0, 1'b0);
        do_op(4'd7, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R8", acc_o, 32'hFFFF_FFFF);          // -15 >>> 6 = -1
        do_op(4'd6, 4'd0, 16'h0002, 16'h0, 1'b0);
        do_op(4'd7, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R8", acc_o, 32'hFFFF_FF0F);          // -1 + (-240)
        // R10: idle codes
        for (int c = 9; c < 16; c++) do_op(4'(c), 4'd3, 16'hABCD, 16'h1234, 1'b1);
        do_op(4'd0, 4'd1, 16'h7777, 16'h0, 1'b0);
        do_op(4'd7, 4'd0, 16'h0, 16'h0, 1'b0);         // product and mode kept

        for (int i = 0; i < 2000; i++) begin
            do_op(4'($urandom_range(0, 15)), 4'($urandom),
                  16'($urandom), 16'($urandom), 1'($urandom));
        end

        // R1: reset in the middle of a run
        do_reset();
        do_op(4'd7, 4'd0, 16'h0, 16'h0, 1'b0);
        check32("R1", acc_o, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule